// File: doc/BRIEF.md
# Flat Panel Window Positioner

The positioner tracks where the panel scan is, in 4-pixel nibble columns and in scan lines, and from that position it decides whether the normal display image covers the current pixel. It works from a pixel-clock enable and from line and frame start strobes. Its outputs are a data-enable window, the image column and image row of the current pixel, and a blank flag. The blank flag marks panel area that the image does not cover.

Horizontal placement is measured against a fixed reference of 0Ah nibbles. An offset above the reference moves the image left by the difference, and an offset below it moves the image right. Vertical placement counts rows down from the panel top. The panel height comes from the vertical-size value, which means a different number of scan lines for single-scan and dual-scan panels. The low byte of each value comes from its own input. The upper bits come from a shared overflow input. Everything is captured into shadow copies at each frame start, so writes made during a frame have no effect on that frame.

Top module: `fp_window_pos`

## Requirements
- R1: After reset and until the first frame_start, de, blank, img_col and img_row are all 0.
- R2: The values are assembled as follows. Column offset = {ovf_bits[0], col_off_lo}. Horizontal size = {ovf_bits[1], hsize_lo}. Row offset = {ovf_bits[3:2], row_off_lo}. Vertical size = {ovf_bits[6:4], vsize_lo}.
- R3: The panel nibble column starts at 0 on frame_start or line_start. It advances by one after every 4 cycles with pix_en high, and it holds while pix_en is low.
- R4: The image column equals panel nibble + column offset − 10. At offset 0Ah the image starts at panel nibble 0. Columns that come out negative are outside the image.
- R5: Panel nibbles above the horizontal size lie outside the panel, and there de and blank are both 0.
- R6: The panel row is 0 at frame_start and increments on each line_start. The image row equals panel row − row offset. Rows above the offset are outside the image.
- R7: With dual_scan = 0, the panel rows run from 0 to the vertical size inclusive. Later rows give de = 0 and blank = 0.
- R8: With dual_scan = 1, the panel rows run from 0 to 2·vsize + 1 inclusive.
- R9: blank is 1 exactly when the pixel lies inside the panel and de is 0.
- R10: Register inputs and dual_scan are sampled only on frame_start. Changes made during a frame leave every output unchanged until the next frame_start.
- R11: img_col and img_row are 0 whenever de is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Panel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_en | input | 1 | One panel pixel per high cycle |
| line_start | input | 1 | Start of a new scan line |
| frame_start | input | 1 | Start of a frame; loads the shadow copies |
| col_off_lo | input | 8 | Column offset, low byte (nibbles) |
| hsize_lo | input | 8 | Horizontal size, low byte (nibbles − 1) |
| row_off_lo | input | 8 | Row offset, low byte |
| vsize_lo | input | 8 | Vertical size, low byte |
| ovf_bits | input | 7 | Upper bits of the four values |
| dual_scan | input | 1 | 1 selects a dual-scan panel |
| de | output | 1 | Pixel is inside the image window |
| blank | output | 1 | Pixel is in panel area not covered by the image |
| img_col | output | 11 | Image column in nibbles (0 when de is 0) |
| img_row | output | 13 | Image row (0 when de is 0) |

## Verification
The hardest case to produce is a register write that lands in the middle of a frame. The outputs must keep following the old shadow values until the next frame_start, and the only evidence of a mistake is a subtle shift of the window. To reach it, the bench changes every register input between two lines of a running frame, checks every remaining pixel of that frame against the old settings, and then starts a new frame to show that the new settings take effect. Nibble values that need the ninth bit are reached with lines more than 256 nibbles long, and pix_en gaps are inserted to show that the column holds still while pix_en is low.

// File: rtl/fp_window_pos.sv
module fp_window_pos #(
  parameter int COL_W   = 9,
  parameter int ROW_W   = 10,
  parameter int VSZ_W   = 11,
  parameter int NIB_PIX = 4,
  parameter int COL_REF = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pix_en,
  input  logic                 line_start,
  input  logic                 frame_start,
  input  logic [7:0]           col_off_lo,
  input  logic [7:0]           hsize_lo,
  input  logic [7:0]           row_off_lo,
  input  logic [7:0]           vsize_lo,
  input  logic [6:0]           ovf_bits,
  input  logic                 dual_scan,
  output logic                 de,
  output logic                 blank,
  output logic [COL_W+1:0]     img_col,
  output logic [VSZ_W+1:0]     img_row
);
  localparam int SUB_W = $clog2(NIB_PIX);
  localparam int NIB_W = COL_W + 1;
  localparam int PRW   = VSZ_W + 2;
  localparam int CSW   = NIB_W + 2;
  localparam int RSW   = PRW + 1;
  localparam int IMG_COL_W = COL_W + 2;
  localparam int IMG_ROW_W = VSZ_W + 2;

  logic [COL_W-1:0] sh_col, sh_hsz;
  logic [ROW_W-1:0] sh_row;
  logic [VSZ_W-1:0] sh_vsz;
  logic             sh_dual, framed;
  logic [SUB_W-1:0] sub;
  logic [NIB_W-1:0] pnib;
  logic [PRW-1:0]   prow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_col <= '0; sh_hsz <= '0; sh_row <= '0; sh_vsz <= '0;
      sh_dual <= 1'b0; framed <= 1'b0;
    end else if (frame_start) begin
      sh_col  <= {ovf_bits[0], col_off_lo};
      sh_hsz  <= {ovf_bits[1], hsize_lo};
      sh_row  <= {ovf_bits[3:2], row_off_lo};
      sh_vsz  <= {ovf_bits[6:4], vsize_lo};
      sh_dual <= dual_scan;
      framed  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub <= '0; pnib <= '0; prow <= '0;
    end else if (frame_start) begin
      sub <= '0; pnib <= '0; prow <= '0;
    end else if (line_start) begin
      sub <= '0; pnib <= '0;
      if (prow != '1) prow <= prow + 1'b1;
    end else if (pix_en) begin
      if (sub == SUB_W'(NIB_PIX - 1)) begin
        sub <= '0;
        if (pnib != '1) pnib <= pnib + 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  logic [CSW-1:0] col_sum;
  logic [RSW-1:0] row_dif;
  logic [PRW-1:0] last_row;
  logic           in_panel;

  assign col_sum  = CSW'(pnib) + CSW'(sh_col) - CSW'(COL_REF);
  assign row_dif  = RSW'(prow) - RSW'(sh_row);
  assign last_row = sh_dual ? PRW'({sh_vsz, 1'b1}) : PRW'(sh_vsz);
  assign in_panel = framed && (NIB_W'(sh_hsz) >= pnib) && (prow <= last_row);

  assign de      = in_panel && !col_sum[CSW-1] && !row_dif[RSW-1];
  assign blank   = in_panel && !de;
  assign img_col = de ? col_sum[IMG_COL_W-1:0] : '0;
  assign img_row = de ? row_dif[IMG_ROW_W-1:0] : '0;
endmodule

// File: rtl/fp_window_pos_chk.sv
module fp_window_pos_chk #(
  parameter int ICW = 11,
  parameter int IRW = 13
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pix_en,
  input logic           line_start,
  input logic           frame_start,
  input logic           de,
  input logic           blank,
  input logic [ICW-1:0] img_col,
  input logic [IRW-1:0] img_row
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else if (frame_start) seen <= 1'b1;

  a_r1_idle_before_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> (!de && !blank && img_col == '0 && img_row == '0));

  a_r9_blank_excludes_de: assert property (@(posedge clk) disable iff (!rst_n)
    !(de && blank));

  a_r11_zero_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (img_col == '0 && img_row == '0));

  a_r3_hold_without_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    (de && !pix_en && !line_start && !frame_start) |=>
      (de && $stable(img_col) && $stable(img_row)));

  a_r6_row_fixed_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    (de && !line_start && !frame_start) |=> (!de || $stable(img_row)));
endmodule

bind fp_window_pos fp_window_pos_chk #(.ICW(IMG_COL_W), .IRW(IMG_ROW_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_start(line_start),
  .frame_start(frame_start), .de(de), .blank(blank),
  .img_col(img_col), .img_row(img_row)
);

// File: tb/fp_window_pos_tb.sv
module fp_window_pos_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pix_en = 0, line_start = 0, frame_start = 0, dual_scan = 0;
  logic [7:0] col_off_lo = 0, hsize_lo = 0, row_off_lo = 0, vsize_lo = 0;
  logic [6:0] ovf_bits = 0;
  logic de, blank;
  logic [10:0] img_col;
  logic [12:0] img_row;

  fp_window_pos dut_i (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_start(line_start),
    .frame_start(frame_start), .col_off_lo(col_off_lo), .hsize_lo(hsize_lo),
    .row_off_lo(row_off_lo), .vsize_lo(vsize_lo), .ovf_bits(ovf_bits),
    .dual_scan(dual_scan), .de(de), .blank(blank),
    .img_col(img_col), .img_row(img_row)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  string tag = "R1";
  int m_framed = 0, m_sub = 0, m_pn = 0, m_prow = 0;
  int s_off = 0, s_hsz = 0, s_roff = 0, s_vsz = 0, s_dual = 0;

  task automatic compare();
    int c, r, last, inp, e_de, e_bl, e_col, e_row;
    bit bad;
    c = m_pn + s_off - 10;
    r = m_prow - s_roff;
    last = s_dual ? 2*s_vsz + 1 : s_vsz;
    inp = (m_framed != 0) && (m_pn <= s_hsz) && (m_prow <= last);
    e_de = inp && c >= 0 && r >= 0;
    e_bl = inp && !e_de;
    e_col = e_de ? c : 0;
    e_row = e_de ? r : 0;
    bad = 0;
    n_chk++;
    if (int'(de) != e_de) begin
      bad = 1; $display("FAIL %s de: actual %0d expected %0d (nib %0d row %0d)", tag, de, e_de, m_pn, m_prow);
    end
    if (int'(blank) != e_bl) begin
      bad = 1; $display("FAIL R9 blank: actual %0d expected %0d (nib %0d row %0d)", blank, e_bl, m_pn, m_prow);
    end
    if (int'(img_col) != e_col) begin
      bad = 1; $display("FAIL %s img_col: actual %0d expected %0d", e_de ? "R4" : "R11", img_col, e_col);
    end
    if (int'(img_row) != e_row) begin
      bad = 1; $display("FAIL %s img_row: actual %0d expected %0d", e_de ? "R6" : "R11", img_row, e_row);
    end
    if (bad) n_bad++;
  endtask

  task automatic step(input bit fs, input bit ls, input bit pe);
    @(negedge clk);
    compare();
    frame_start = fs; line_start = ls; pix_en = pe;
    cyc++;
    if (fs) begin
      m_framed = 1; m_sub = 0; m_pn = 0; m_prow = 0;
      s_off  = {ovf_bits[0], col_off_lo};
      s_hsz  = {ovf_bits[1], hsize_lo};
      s_roff = {ovf_bits[3:2], row_off_lo};
      s_vsz  = {ovf_bits[6:4], vsize_lo};
      s_dual = dual_scan;
    end else if (ls) begin
      m_prow++; m_sub = 0; m_pn = 0;
    end else if (pe) begin
      if (m_sub == 3) begin m_sub = 0; m_pn++; end else m_sub++;
    end
  endtask

  task automatic run_line(input bit first, input int nibs, input bit gaps);
    int k;
    if (!first) step(0, 1, 0);
    k = 0;
    while (k < nibs*4) begin
      if (gaps && (cyc % 3 == 2)) step(0, 0, 0);
      else begin step(0, 0, 1); k++; end
    end
  endtask

  task automatic run_frame(input int lines, input int nibs, input bit gaps);
    step(1, 0, 0);
    for (int l = 0; l < lines; l++) run_line(l == 0, nibs, gaps);
  endtask

  task automatic set_regs(input int col, input int hsz, input int roff,
                          input int vsz, input int ovf, input bit dual);
    col_off_lo = 8'(col); hsize_lo = 8'(hsz); row_off_lo = 8'(roff);
    vsize_lo = 8'(vsz); ovf_bits = 7'(ovf); dual_scan = dual;
  endtask

  bit done = 0;
  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle until the first frame start, even with line and pixel activity
    tag = "R1";
    set_regs(10, 5, 0, 3, 0, 0);
    for (int i = 0; i < 12; i++) step(0, i == 5, 1);
    // R4 / R5: sweep column offset around 0Ah, lines longer than the panel
    tag = "R4";
    for (int off = 6; off <= 14; off++) begin
      set_regs(off, 5, 1, 3, 0, 0);
      run_frame(3, 8, 0);
    end
    tag = "R5";
    set_regs(10, 2, 0, 1, 0, 0);
    run_frame(2, 6, 0);
    // R6 / R7: row offset sweep on a single-scan panel
    tag = "R6";
    for (int ro = 0; ro <= 4; ro++) begin
      set_regs(10, 3, ro, 2, 0, 0);
      run_frame(7, 5, 0);
    end
    tag = "R7";
    set_regs(11, 3, 0, 0, 0, 0);
    run_frame(4, 5, 0);
    // R8: dual-scan panel height 2*vsize+2 lines
    tag = "R8";
    for (int ro = 0; ro <= 2; ro += 2) begin
      set_regs(10, 3, ro, 1, 0, 1);
      run_frame(6, 5, 0);
    end
    // R3: pixel enable gaps hold the nibble column
    tag = "R3";
    set_regs(9, 4, 1, 3, 0, 0);
    run_frame(4, 6, 1);
    // R2: upper bits from the overflow input
    tag = "R2";
    set_regs(10, 2, 0, 3, 7'h03, 0);
    run_frame(2, 262, 0);
    set_regs(10, 4, 1, 3, 7'h0C, 0);
    run_frame(3, 6, 0);
    set_regs(10, 4, 0, 0, 7'h10, 0);
    run_frame(5, 6, 0);
    set_regs(10, 4, 0, 0, 7'h00, 0);
    run_frame(5, 6, 0);
    // R10: changes inside a frame wait for the next frame start
    tag = "R10";
    set_regs(10, 4, 0, 5, 0, 0);
    step(1, 0, 0);
    run_line(1, 6, 0);
    run_line(0, 6, 0);
    set_regs(7, 1, 2, 0, 7'h7F, 1);
    run_line(0, 6, 0);
    run_line(0, 6, 0);
    run_frame(4, 6, 0);
    step(0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule